// File: doc/BRIEF.md
# Video Field Size Enforcer

This block sits in a ready/valid pixel stream and trims every incoming video field to a programmed number of pixels per line and lines per field. Pixels that lie past the programmed width are discarded, and so are whole lines that lie past the programmed height. When a line is cut short, the last pixel kept is marked as end of line. Lines and fields that are shorter than the programmed size pass through as they are. No padding is added.

A 32-bit register port gives software access to the block. Through it, software can read the build parameters, program the target width and height, and poll a flag that shows whether a field is being produced. A new width takes effect only at the next line start, and a new height only at the next field start. A field never changes size part way through a line. The stream path has no register stage: kept pixels go straight from input to output in the same cycle, and dropped pixels are accepted at once.

Top module: `field_size_enforcer`

## Requirements
- R1: Offset 0x000 always reads 0x0000027C. Offset 0x004 reads the VERSION_ID parameter. Offset 0x008 reads 1, which marks the reduced operating mode. Offset 0x00C reads 0, meaning debug is absent.
- R2: The parameter registers read as follows: offset 0x010 gives bits per symbol, 0x014 gives pixels per beat (always 1), 0x018 gives the maximum width and 0x01C gives the maximum height.
- R3: The width register is at offset 0x120, bits [15:0]. Its reset value is the maximum width, and it reads back the last value written. A written width first applies to the next line start. A line start is a beat carrying start of field, or the first beat accepted after an end-of-line beat.
- R4: The height register is at offset 0x124, bits [15:0]. Its reset value is the maximum height, and it reads back the last value written. A written height first applies to the next beat carrying start of field.
- R5: Within a line, input pixels at column index greater than or equal to the active width produce no output beat. When a line is truncated, the pixel at column width-1 leaves with outEol set.
- R6: Within a field, every pixel of a line whose row index is greater than or equal to the active height produces no output beat.
- R7: A kept pixel passes in the same cycle with unchanged data and markers, with outValid equal to inValid and inReady equal to outReady. While a pixel is being dropped, inReady is 1 and outValid is 0.
- R8: Lines shorter than the width and fields shorter than the height pass unchanged, with no padding. An input end of line always ends the output line.
- R9: Bit 0 at offset 0x140 becomes 1 after an output beat that carries start of field. It becomes 0 after an output end-of-line beat on row height-1, and clearing wins if both happen on the same beat. Bits [31:1] read 0.
- R10: Offsets that are not listed, and unaligned offsets, read 0. Writes to them, and writes to read-only offsets, change nothing.
- R11: A start-of-field beat arriving mid-line restarts both column and row counting from zero at that beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| regAddr | input | REG_ADDR_W | Register byte offset |
| regWe | input | 1 | Register write strobe |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data for regAddr, combinational |
| inValid | input | 1 | Input pixel valid |
| inReady | output | 1 | Input pixel accepted |
| inData | input | BITS_PER_SYMBOL*SYMBOLS_PER_PIXEL | Input pixel |
| inSof | input | 1 | Input pixel is first of a field |
| inEol | input | 1 | Input pixel is last of its line |
| outValid | output | 1 | Output pixel valid |
| outReady | input | 1 | Downstream ready |
| outData | output | BITS_PER_SYMBOL*SYMBOLS_PER_PIXEL | Output pixel |
| outSof | output | 1 | Output pixel is first of a field |
| outEol | output | 1 | Output pixel is last of its line |

## Verification
The bench builds the block with a maximum field of 8 by 6 and 16-bit pixels. Input lines of 10 pixels and fields of 8 lines therefore overrun the limits right away, so column and row trimming both appear within a few dozen beats. The programmed size is also lowered to as little as 2 by 2, and writes land in the middle of a field, so each deferred update can be seen taking effect on the line or field after the one in progress. Random input gaps and downstream stalls exercise how ready and valid combine while pixels are being dropped.

// File: rtl/fse_pkg.sv
package fse_pkg;
  localparam int DIM_W = 16;

  localparam logic [11:0] OFF_ID      = 12'h000;
  localparam logic [11:0] OFF_VERSION = 12'h004;
  localparam logic [11:0] OFF_MODE    = 12'h008;
  localparam logic [11:0] OFF_DEBUG   = 12'h00C;
  localparam logic [11:0] OFF_BPS     = 12'h010;
  localparam logic [11:0] OFF_PAR     = 12'h014;
  localparam logic [11:0] OFF_MAXW    = 12'h018;
  localparam logic [11:0] OFF_MAXH    = 12'h01C;
  localparam logic [11:0] OFF_WIDTH   = 12'h120;
  localparam logic [11:0] OFF_HEIGHT  = 12'h124;
  localparam logic [11:0] OFF_STATUS  = 12'h140;

  localparam logic [31:0] ID_VALUE = 32'h0000_027C;

  // pending geometry handed from control to datapath
  typedef struct packed {
    logic [DIM_W-1:0] pendW;
    logic [DIM_W-1:0] pendH;
  } fse_cfg_t;

  // strobes from datapath back to control
  typedef struct packed {
    logic fieldOpen;
    logic fieldClose;
  } fse_evt_t;
endpackage

// File: rtl/fse_regs.sv
module fse_regs
  import fse_pkg::*;
#(
  parameter int          BPS     = 10,
  parameter int          MAX_W   = 1920,
  parameter int          MAX_H   = 1080,
  parameter logic [31:0] VERSION = 32'h0001_0000,
  parameter int          ADDR_W  = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  fse_evt_t          evt,
  output fse_cfg_t          cfg,
  output logic              fieldActive
);
  localparam int PIX_PAR = 1;

  logic [DIM_W-1:0] shadowW, shadowH;
  logic             activeQ;
  logic             unusedHi;

  assign unusedHi = ^regWdata[31:DIM_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      shadowW <= DIM_W'(MAX_W);
      shadowH <= DIM_W'(MAX_H);
      activeQ <= 1'b0;
    end else begin
      if (regWe && regAddr == ADDR_W'(OFF_WIDTH))  shadowW <= regWdata[DIM_W-1:0];
      if (regWe && regAddr == ADDR_W'(OFF_HEIGHT)) shadowH <= regWdata[DIM_W-1:0];
      activeQ <= (activeQ | evt.fieldOpen) & ~evt.fieldClose;
    end
  end

  always_comb begin
    case (regAddr)
      ADDR_W'(OFF_ID):      regRdata = ID_VALUE;
      ADDR_W'(OFF_VERSION): regRdata = VERSION;
      ADDR_W'(OFF_MODE):    regRdata = 32'd1;
      ADDR_W'(OFF_DEBUG):   regRdata = 32'd0;
      ADDR_W'(OFF_BPS):     regRdata = 32'(BPS);
      ADDR_W'(OFF_PAR):     regRdata = 32'(PIX_PAR);
      ADDR_W'(OFF_MAXW):    regRdata = 32'(MAX_W);
      ADDR_W'(OFF_MAXH):    regRdata = 32'(MAX_H);
      ADDR_W'(OFF_WIDTH):   regRdata = 32'(shadowW);
      ADDR_W'(OFF_HEIGHT):  regRdata = 32'(shadowH);
      ADDR_W'(OFF_STATUS):  regRdata = {31'd0, activeQ};
      default:              regRdata = 32'd0;
    endcase
  end

  assign cfg.pendW   = shadowW;
  assign cfg.pendH   = shadowH;
  assign fieldActive = activeQ;
endmodule

// File: rtl/fse_path.sv
module fse_path
  import fse_pkg::*;
#(
  parameter int DATA_W = 30,
  parameter int MAX_W  = 1920,
  parameter int MAX_H  = 1080
) (
  input  logic              clk,
  input  logic              rst,
  input  fse_cfg_t          cfg,
  output fse_evt_t          evt,
  input  logic              inValid,
  output logic              inReady,
  input  logic [DATA_W-1:0] inData,
  input  logic              inSof,
  input  logic              inEol,
  output logic              outValid,
  input  logic              outReady,
  output logic [DATA_W-1:0] outData,
  output logic              outSof,
  output logic              outEol
);
  logic [DIM_W-1:0] actW, actH, colQ, rowQ;
  logic             atLineStartQ;
  logic             lineStart, keep, lastCol, lastRow, inBeat, outBeat;
  logic [DIM_W-1:0] effW, effH, curCol, curRow, colInc, rowInc;

  always_comb begin
    lineStart = inSof | atLineStartQ;
    effW      = lineStart ? cfg.pendW : actW;
    effH      = inSof ? cfg.pendH : actH;
    curCol    = lineStart ? '0 : colQ;
    curRow    = inSof ? '0 : rowQ;
    keep      = (curCol < effW) && (curRow < effH);
    lastCol   = ({1'b0, curCol} + 1'b1) == {1'b0, effW};
    lastRow   = ({1'b0, curRow} + 1'b1) == {1'b0, effH};
    colInc    = (&curCol) ? curCol : curCol + 1'b1;
    rowInc    = (&curRow) ? curRow : curRow + 1'b1;
  end

  assign outValid = inValid & keep;
  assign inReady  = keep ? outReady : 1'b1;
  assign outData  = inData;
  assign outSof   = inSof;
  assign outEol   = inEol | lastCol;
  assign inBeat   = inValid & inReady;
  assign outBeat  = outValid & outReady;

  assign evt.fieldOpen  = outBeat & inSof;
  assign evt.fieldClose = outBeat & outEol & lastRow;

  always_ff @(posedge clk) begin
    if (rst) begin
      actW         <= DIM_W'(MAX_W);
      actH         <= DIM_W'(MAX_H);
      colQ         <= '0;
      rowQ         <= '0;
      atLineStartQ <= 1'b1;
    end else if (inBeat) begin
      if (lineStart) actW <= effW;
      if (inSof)     actH <= effH;
      colQ         <= inEol ? '0 : colInc;
      rowQ         <= inEol ? rowInc : curRow;
      atLineStartQ <= inEol;
    end
  end
endmodule

// File: rtl/field_size_enforcer.sv
module field_size_enforcer
  import fse_pkg::*;
#(
  parameter int          BITS_PER_SYMBOL   = 10,
  parameter int          SYMBOLS_PER_PIXEL = 3,
  parameter int          MAX_WIDTH         = 1920,
  parameter int          MAX_HEIGHT        = 1080,
  parameter logic [31:0] VERSION_ID        = 32'h0001_0000,
  parameter int          REG_ADDR_W        = 9,
  localparam int         DATA_W            = BITS_PER_SYMBOL * SYMBOLS_PER_PIXEL
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic                  regWe,
  input  logic [31:0]           regWdata,
  output logic [31:0]           regRdata,
  input  logic                  inValid,
  output logic                  inReady,
  input  logic [DATA_W-1:0]     inData,
  input  logic                  inSof,
  input  logic                  inEol,
  output logic                  outValid,
  input  logic                  outReady,
  output logic [DATA_W-1:0]     outData,
  output logic                  outSof,
  output logic                  outEol
);
  fse_cfg_t cfg;
  fse_evt_t evt;
  logic     fieldActive;

  fse_regs #(
    .BPS(BITS_PER_SYMBOL), .MAX_W(MAX_WIDTH), .MAX_H(MAX_HEIGHT),
    .VERSION(VERSION_ID), .ADDR_W(REG_ADDR_W)
  ) i_regs (
    .clk(clk), .rst(rst), .regAddr(regAddr), .regWe(regWe),
    .regWdata(regWdata), .regRdata(regRdata), .evt(evt), .cfg(cfg),
    .fieldActive(fieldActive)
  );

  fse_path #(.DATA_W(DATA_W), .MAX_W(MAX_WIDTH), .MAX_H(MAX_HEIGHT)) i_path (
    .clk(clk), .rst(rst), .cfg(cfg), .evt(evt),
    .inValid(inValid), .inReady(inReady), .inData(inData), .inSof(inSof), .inEol(inEol),
    .outValid(outValid), .outReady(outReady), .outData(outData), .outSof(outSof), .outEol(outEol)
  );
endmodule

// File: rtl/fse_checker.sv
module fse_checker #(
  parameter int ADDR_W = 9
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] regAddr,
  input logic [31:0]       regRdata,
  input logic              inValid,
  input logic              inReady,
  input logic              outValid,
  input logic              outReady,
  input logic              outSof,
  input logic              outEol,
  input logic              fieldActive
);
  AST_NO_INVENTED_BEAT: assert property (@(posedge clk) disable iff (rst)
    outValid |-> inValid);                                              // R7
  AST_DROP_KEEPS_READY: assert property (@(posedge clk) disable iff (rst)
    (inValid && !outValid) |-> inReady);                                // R7
  AST_READY_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (inReady == outReady));                                // R7
  AST_ID_VALUE: assert property (@(posedge clk) disable iff (rst)
    (regAddr == ADDR_W'(12'h000)) |-> (regRdata == 32'h0000_027C));     // R1
  AST_STATUS_RISE: assert property (@(posedge clk) disable iff (rst)
    (outValid && outReady && outSof && !outEol) |=> fieldActive);       // R9
  AST_STATUS_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (regAddr == ADDR_W'(12'h140)) |-> (regRdata[31:1] == 31'd0));       // R9
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (regAddr == ADDR_W'(12'h100)) |-> (regRdata == 32'd0));             // R10
endmodule

bind field_size_enforcer fse_checker #(.ADDR_W(REG_ADDR_W)) i_chk (.*);

// File: tb/test_field_size_enforcer.sv
module test_field_size_enforcer;
  localparam int BPS = 8, SYMS = 2, DW = 16, MW = 8, MH = 6;
  localparam logic [31:0] VER = 32'h0000_2301;
  localparam logic [8:0] A_STATUS = 9'h140;

  logic clk = 1'b0, rst = 1'b1;
  logic [8:0] regAddr = 9'h0;
  logic regWe = 1'b0;
  logic [31:0] regWdata = '0, regRdata;
  logic inValid = 1'b0, inReady, inSof = 1'b0, inEol = 1'b0;
  logic [DW-1:0] inData = '0, outData;
  logic outValid, outReady = 1'b1, outSof, outEol;

  always #10 clk = ~clk;

  field_size_enforcer #(
    .BITS_PER_SYMBOL(BPS), .SYMBOLS_PER_PIXEL(SYMS), .MAX_WIDTH(MW),
    .MAX_HEIGHT(MH), .VERSION_ID(VER), .REG_ADDR_W(9)
  ) i_field_size_enforcer (.*);

  int checks = 0, errors = 0;
  string phaseTag = "R7";
  logic [17:0] pixQ[$];
  int pixCnt = 0;
  bit acceptNext = 0, randReady = 0, randValid = 0;

  // reference model state
  int mShW, mShH, mActW, mActH, mCol, mRow;
  bit mAtLs, mStatus;

  task automatic chk(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic longint modelRead(logic [8:0] a, output string tag);
    tag = "R10";
    case (a)
      9'h000: begin tag = "R1"; return 32'h27C; end
      9'h004: begin tag = "R1"; return VER; end
      9'h008: begin tag = "R1"; return 1; end
      9'h00C: begin tag = "R1"; return 0; end
      9'h010: begin tag = "R2"; return BPS; end
      9'h014: begin tag = "R2"; return 1; end
      9'h018: begin tag = "R2"; return MW; end
      9'h01C: begin tag = "R2"; return MH; end
      9'h120: begin tag = "R3"; return mShW; end
      9'h124: begin tag = "R4"; return mShH; end
      9'h140: begin tag = "R9"; return mStatus; end
      default: return 0;
    endcase
  endfunction

  // driver
  always @(negedge clk) begin
    if (!rst) begin
      if (acceptNext) void'(pixQ.pop_front());
      if (pixQ.size() > 0 && ((inValid && !acceptNext) || !randValid || $urandom_range(3) != 0)) begin
        inValid = 1'b1;
        {inSof, inEol, inData} = pixQ[0];
      end else begin
        inValid = 1'b0;
        inSof = 1'b0;
        inEol = 1'b0;
      end
      outReady = randReady ? ($urandom_range(3) != 0) : 1'b1;
    end
  end

  // monitor and reference model, sampled mid low phase
  always @(negedge clk) begin
    #5;
    if (rst) begin
      mShW = MW; mShH = MH; mActW = MW; mActH = MH;
      mCol = 0; mRow = 0; mAtLs = 1; mStatus = 0; acceptNext = 0;
    end else begin
      string rtag, ktag;
      bit ls, keep, expEol, expReady, ob;
      int effW, effH, cc, rr;
      longint ev;
      ev = modelRead(regAddr, rtag);
      chk(rtag, "regRdata", regRdata, ev);
      ls = inSof || mAtLs;
      effW = ls ? mShW : mActW;
      effH = inSof ? mShH : mActH;
      cc = ls ? 0 : mCol;
      rr = inSof ? 0 : mRow;
      keep = (cc < effW) && (rr < effH);
      expEol = inEol || (cc + 1 == effW);
      ktag = !keep ? ((rr >= effH) ? "R6" : "R5") : (expEol && !inEol) ? "R5" : phaseTag;
      expReady = keep ? outReady : 1'b1;
      chk(ktag, "outValid", outValid, inValid && keep);
      if (inValid) chk(ktag, "inReady", inReady, expReady);
      if (inValid && keep) begin
        chk(ktag, "outData", outData, inData);
        chk(ktag, "outSof", outSof, inSof);
        chk(ktag, "outEol", outEol, expEol);
      end
      acceptNext = inValid && expReady;
      ob = inValid && keep && outReady;
      if (acceptNext) begin
        if (ls) mActW = effW;
        if (inSof) mActH = effH;
        mCol = inEol ? 0 : cc + 1;
        mRow = inEol ? rr + 1 : rr;
        mAtLs = inEol;
      end
      mStatus = (mStatus || (ob && inSof)) && !(ob && expEol && (rr + 1 == effH));
      if (regWe && regAddr == 9'h120) mShW = regWdata[15:0];
      if (regWe && regAddr == 9'h124) mShH = regWdata[15:0];
    end
  end

  task automatic sendField(int w, int h);
    for (int r = 0; r < h; r++)
      for (int c = 0; c < w; c++) begin
        pixQ.push_back({(r == 0 && c == 0), (c == w - 1), 16'(pixCnt)});
        pixCnt++;
      end
  endtask

  task automatic drain();
    wait (pixQ.size() == 0 && !inValid);
    @(negedge clk);
  endtask

  task automatic regWrite(logic [8:0] a, logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0; regAddr = A_STATUS;
  endtask

  task automatic readCheck(logic [8:0] a, longint exp, string tag);
    @(negedge clk);
    regAddr = a;
    #5 chk(tag, "explicit read", regRdata, exp);
    @(negedge clk);
    regAddr = A_STATUS;
  endtask

  task automatic mainSeq();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // reset state and parameter registers
    readCheck(9'h000, 32'h27C, "R1");
    readCheck(9'h004, VER, "R1");
    readCheck(9'h008, 1, "R1");
    readCheck(9'h00C, 0, "R1");
    readCheck(9'h010, BPS, "R2");
    readCheck(9'h014, 1, "R2");
    readCheck(9'h018, MW, "R2");
    readCheck(9'h01C, MH, "R2");
    readCheck(9'h120, MW, "R3");
    readCheck(9'h124, MH, "R4");
    readCheck(A_STATUS, 0, "R9");
    readCheck(9'h0F0, 0, "R10");
    // full size field at the limits
    sendField(MW, MH); drain();
    readCheck(A_STATUS, 0, "R9");
    // trim width and height
    regWrite(9'h120, 5); regWrite(9'h124, 4);
    readCheck(9'h120, 5, "R3");
    readCheck(9'h124, 4, "R4");
    sendField(8, 6); drain();
    sendField(10, 8); drain();
    readCheck(A_STATUS, 0, "R9");
    // stalls and gaps
    randReady = 1; randValid = 1;
    sendField(10, 8); sendField(7, 5); drain();
    // short field passes untouched, status stays open
    phaseTag = "R8";
    sendField(3, 2); drain();
    readCheck(A_STATUS, 1, "R9");
    // width written mid-field applies at next line start
    phaseTag = "R3";
    sendField(8, 6);
    wait (pixQ.size() < 30);
    regWrite(9'h120, 2);
    drain();
    // height written mid-field applies at next field
    phaseTag = "R4";
    sendField(6, 6);
    wait (pixQ.size() < 20);
    regWrite(9'h124, 2);
    drain();
    sendField(6, 6); drain();
    readCheck(A_STATUS, 0, "R9");
    // writes to reserved and read-only offsets
    phaseTag = "R10";
    regWrite(9'h128, 32'hFFFF_FFFF);
    regWrite(9'h000, 32'h1234_5678);
    regWrite(9'h018, 32'h55);
    readCheck(9'h128, 0, "R10");
    readCheck(9'h000, 32'h27C, "R10");
    readCheck(9'h018, MW, "R10");
    readCheck(9'h122, 0, "R10");
    regWrite(9'h120, 4); regWrite(9'h124, 3);
    sendField(6, 4); drain();
    // start of field arriving mid-line
    phaseTag = "R11";
    for (int c = 0; c < 3; c++) begin
      pixQ.push_back({(c == 0), 1'b0, 16'(pixCnt)}); pixCnt++;
    end
    sendField(6, 4); drain();
    readCheck(A_STATUS, 0, "R11");
    repeat (5) @(negedge clk);
  endtask

  initial begin
    fork
      mainSeq();
      begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog run did not complete actual=%0d expected=%0d", pixQ.size(), 0);
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule